// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 32-bit physical address. It reads two entries from a table tree held in memory. The top ten address bits pick an entry in a directory whose 4 KiB page base comes from the `dir_base` input. That entry, when valid, names a second-level table. The next ten bits pick an entry in that table. The low twelve bits pass unchanged into the physical address.

A client presents a request with an access type (read or write). The walker takes it when `req_ready` is high. It then issues one single-word read per level on a plain request/response memory port. After the walk it raises `rsp_valid` for one cycle with one of three outcomes:
- a translation, carrying the physical address and the entry's attribute flags;
- a page fault, carrying the virtual address and the access type;
- a bus error, carrying the virtual address and the access type.

Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first fetch reads address `{dir_base[31:12], vaddr[31:22], 2'b00}`. Bits 11:0 of `dir_base` have no effect.
- R3: If the first entry has bit 0 (valid) set, the second fetch reads `{entry1[31:12], vaddr[21:12], 2'b00}`. Bits 11:1 of the first entry have no effect.
- R4: On success `rsp_kind` is 0 (ok), `rsp_addr` is `{entry2[31:12], vaddr[11:0]}` and `rsp_flags` is `entry2[8:1]`.
- R5: A clear bit 0 in either entry gives `rsp_kind` 1 (fault), with `rsp_addr` = vaddr and `rsp_flags` 0. An invalid first entry causes no second fetch.
- R6: A write needs bit 2 (writable) of the second entry, and a read needs bit 1 (readable). Without the needed bit, the walk ends in a fault (`rsp_kind` 1).
- R7: A response with `mem_rsp_err` high on either fetch gives `rsp_kind` 2 (bus error) with `rsp_addr` = vaddr, and no further fetch is made.
- R8: `req_ready` is low from the cycle after acceptance through the response cycle. A `req_valid` seen during that time is ignored.
- R9: `rsp_valid` lasts exactly one cycle per walk. `mem_req_valid` lasts one cycle per fetch. `rsp_write` returns the access type of the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Directory page base; bits 31:12 are used |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| mem_req_valid | output | 1 | One-cycle table read request |
| mem_req_addr | output | 32 | Word address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry value |
| mem_rsp_err | input | 1 | Read failed on the bus |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_kind | output | 2 | 0 ok, 1 page fault, 2 bus error |
| rsp_addr | output | 32 | Physical address on ok, virtual address otherwise |
| rsp_flags | output | 8 | Entry bits 8:1 on ok, else 0 |
| rsp_write | output | 1 | Access type of the finished walk |

## Verification
A wrong fetch address shows on `mem_req_addr` one cycle after acceptance for the first level, and one cycle after the first response for the second level. In either case the wrong entry's data then reaches `rsp_addr` or `rsp_kind` within the same walk. A stuck or wrong state shows as:
- an extra or missing fetch in the per-walk read count;
- a `req_ready` that stays high during a walk;
- a response that never arrives, which the watchdog catches.

Errors in the flag extraction or the permission test appear in the response cycle of the walk that exercises them.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int AW     = 2 * IDX_W + OFF_W;
  localparam int PG_W   = AW - OFF_W;
  localparam int FLAG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH1, ST_FETCH2, ST_DONE, ST_ERROR
  } wstate_t;

  localparam logic [1:0] RES_OK     = 2'd0;
  localparam logic [1:0] RES_FAULT  = 2'd1;
  localparam logic [1:0] RES_BUSERR = 2'd2;

  // word address of an entry inside a table page
  function automatic logic [AW-1:0] entry_addr(input logic [PG_W-1:0] page,
                                               input logic [IDX_W-1:0] idx);
    return {page, idx, 2'b00};
  endfunction

  function automatic logic [AW-1:0] phys_addr(input logic [PG_W-1:0] page,
                                              input logic [OFF_W-1:0] off);
    return {page, off};
  endfunction

  function automatic logic access_allowed(input logic can_rd, input logic can_wr,
                                          input logic is_wr);
    return is_wr ? can_wr : can_rd;
  endfunction
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rsp_valid,
  input  logic mem_rsp_err,
  input  logic ent_valid,
  input  logic ent_perm,
  output logic req_ready,
  output logic accept,
  output logic lvl2,
  output logic mem_req_valid,
  output logic adv2,
  output logic fin_ok,
  output logic fin_fault,
  output logic fin_err,
  output logic rsp_valid
);
  wstate_t st, nxt;
  logic    pend;
  logic    take;

  assign req_ready     = (st == ST_IDLE);
  assign accept        = req_ready && req_valid;
  assign lvl2          = (st == ST_FETCH2);
  assign mem_req_valid = ((st == ST_FETCH1) || (st == ST_FETCH2)) && !pend;
  assign take          = pend && mem_rsp_valid;
  assign rsp_valid     = (st == ST_DONE) || (st == ST_ERROR);
  assign adv2          = (st == ST_FETCH1) && take && !mem_rsp_err && ent_valid;

  always_comb begin
    nxt       = st;
    fin_ok    = 1'b0;
    fin_fault = 1'b0;
    fin_err   = 1'b0;
    case (st)
      ST_IDLE: if (accept) nxt = ST_FETCH1;
      ST_FETCH1: if (take) begin
        if (mem_rsp_err)     begin nxt = ST_ERROR; fin_err   = 1'b1; end
        else if (!ent_valid) begin nxt = ST_DONE;  fin_fault = 1'b1; end
        else                       nxt = ST_FETCH2;
      end
      ST_FETCH2: if (take) begin
        if (mem_rsp_err)                    begin nxt = ST_ERROR; fin_err   = 1'b1; end
        else if (!(ent_valid && ent_perm))  begin nxt = ST_DONE;  fin_fault = 1'b1; end
        else                                begin nxt = ST_DONE;  fin_ok    = 1'b1; end
      end
      ST_DONE, ST_ERROR: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pend <= 1'b0;
    end else begin
      st <= nxt;
      if (mem_req_valid) pend <= 1'b1;
      else if (take)     pend <= 1'b0;
    end
  end

  // R8: once a request is taken the walker stays busy
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R9: result strobe is a single cycle
  a_r9_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9: each fetch is a single-cycle request
  a_r9_fetch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  // R5: invalid first entry finishes the walk without a second fetch
  a_r5_l1_invalid_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH1 && take && !mem_rsp_err && !ent_valid) |=> (rsp_valid && !mem_req_valid));
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [AW-1:0]     req_vaddr,
  input  logic              req_write,
  input  logic [AW-1:0]     dir_base,
  input  logic              lvl2,
  input  logic              adv2,
  input  logic              fin_ok,
  input  logic              fin_fault,
  input  logic              fin_err,
  input  logic [AW-1:0]     mem_rsp_data,
  output logic [AW-1:0]     mem_req_addr,
  output logic              ent_valid,
  output logic              ent_perm,
  output logic [1:0]        rsp_kind,
  output logic [AW-1:0]     rsp_addr,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic              rsp_write
);
  logic [AW-1:0]   va_q;
  logic            wr_q;
  logic [PG_W-1:0] tbl_q;
  logic            unused_bits;

  assign unused_bits = ^{dir_base[OFF_W-1:0], mem_rsp_data[OFF_W-1:FLAG_W+1]};

  assign mem_req_addr = lvl2 ? entry_addr(tbl_q, va_q[OFF_W +: IDX_W])
                             : entry_addr(dir_base[AW-1:OFF_W], va_q[AW-1 -: IDX_W]);
  assign ent_valid = mem_rsp_data[0];
  assign ent_perm  = access_allowed(mem_rsp_data[1], mem_rsp_data[2], wr_q);
  assign rsp_write = wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q      <= '0;
      wr_q      <= 1'b0;
      tbl_q     <= '0;
      rsp_kind  <= RES_OK;
      rsp_addr  <= '0;
      rsp_flags <= '0;
    end else begin
      if (accept) begin
        va_q <= req_vaddr;
        wr_q <= req_write;
      end
      if (adv2) tbl_q <= mem_rsp_data[AW-1:OFF_W];
      if (fin_ok) begin
        rsp_kind  <= RES_OK;
        rsp_addr  <= phys_addr(mem_rsp_data[AW-1:OFF_W], va_q[OFF_W-1:0]);
        rsp_flags <= mem_rsp_data[FLAG_W:1];
      end else if (fin_fault || fin_err) begin
        rsp_kind  <= fin_err ? RES_BUSERR : RES_FAULT;
        rsp_addr  <= va_q;
        rsp_flags <= '0;
      end
    end
  end

  // R9: finishing events are mutually exclusive
  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fin_ok, fin_fault, fin_err}) <= 1);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_vaddr,
  input  logic              req_write,
  output logic              mem_req_valid,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [AW-1:0]     mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [AW-1:0]     rsp_addr,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic              rsp_write
);
  logic accept, lvl2, adv2, fin_ok, fin_fault, fin_err, ent_valid, ent_perm;
  logic err_seen;

  ptw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .ent_valid(ent_valid), .ent_perm(ent_perm),
    .req_ready(req_ready), .accept(accept), .lvl2(lvl2),
    .mem_req_valid(mem_req_valid), .adv2(adv2),
    .fin_ok(fin_ok), .fin_fault(fin_fault), .fin_err(fin_err),
    .rsp_valid(rsp_valid)
  );

  ptw_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_vaddr(req_vaddr),
    .req_write(req_write), .dir_base(dir_base), .lvl2(lvl2), .adv2(adv2),
    .fin_ok(fin_ok), .fin_fault(fin_fault), .fin_err(fin_err),
    .mem_rsp_data(mem_rsp_data), .mem_req_addr(mem_req_addr),
    .ent_valid(ent_valid), .ent_perm(ent_perm), .rsp_kind(rsp_kind),
    .rsp_addr(rsp_addr), .rsp_flags(rsp_flags), .rsp_write(rsp_write)
  );

  assign err_seen = fin_err;

  // R7: bus error on a fetch is reported as its own outcome next cycle
  a_r7_buserr_reported: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |=> (rsp_valid && rsp_kind == RES_BUSERR));
  // R6: a successful result always carries the permission it needed
  a_r6_perm_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RES_OK) |-> (rsp_write ? rsp_flags[1] : rsp_flags[0]));
  // R8: never ready while a result is being presented
  a_r8_not_ready_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = 32'h0001_0ABC;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_addr;
  logic [7:0]  rsp_flags;
  logic        rsp_write;

  int n_chk = 0, n_fail = 0, cyc = 0, lat = 1, cnt = 0, nreq = 0;
  logic [31:0] pend_addr, a1, a2;

  always #4 clk = ~clk;

  pt_walker u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      report();
    end
  end

  // memory image: directory at 0x10000, one table at 0x20000
  task automatic mem_lookup(input logic [31:0] a, output logic [31:0] d, output logic e);
    e = 1'b0; d = 32'h0;
    case (a)
      32'h0001_0004: d = 32'h0002_0FFF;
      32'h0001_0008: d = 32'h0003_0000;
      32'h0001_000C: e = 1'b1;
      32'h0002_0000: d = 32'hABCD_E1FF;
      32'h0002_0004: d = 32'h1234_5003;
      32'h0002_0008: d = 32'h5555_5005;
      32'h0002_000C: d = 32'h6666_61FE;
      32'h0002_0010: e = 1'b1;
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        logic [31:0] d; logic e;
        mem_lookup(pend_addr, d, e);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = d;
        mem_rsp_err   = e;
      end
    end
    if (mem_req_valid) begin
      cnt = lat;
      pend_addr = mem_req_addr;
      nreq++;
      if (nreq == 1) a1 = mem_req_addr;
      if (nreq == 2) a2 = mem_req_addr;
    end
  end

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [7:0]  flags;
    logic [1:0]  nreq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_0ABC, 1'b0, 2'd0, 32'hABCD_EABC, 8'hFF, 2'd2},  // R4 ok read
    '{32'h0040_0123, 1'b1, 2'd0, 32'hABCD_E123, 8'hFF, 2'd2},  // R4 ok write
    '{32'h0040_1FFF, 1'b0, 2'd0, 32'h1234_5FFF, 8'h01, 2'd2},  // R6 read-only ok
    '{32'h0040_1000, 1'b1, 2'd1, 32'h0040_1000, 8'h00, 2'd2},  // R6 write to read-only
    '{32'h0040_2010, 1'b1, 2'd0, 32'h5555_5010, 8'h02, 2'd2},  // R6 write-only ok
    '{32'h0040_2010, 1'b0, 2'd1, 32'h0040_2010, 8'h00, 2'd2},  // R6 read of write-only
    '{32'h0040_3000, 1'b0, 2'd1, 32'h0040_3000, 8'h00, 2'd2},  // R5 level-2 invalid
    '{32'h0080_0000, 1'b1, 2'd1, 32'h0080_0000, 8'h00, 2'd1},  // R5 level-1 invalid
    '{32'h00C0_0000, 1'b1, 2'd2, 32'h00C0_0000, 8'h00, 2'd1},  // R7 level-1 bus error
    '{32'h0040_4000, 1'b0, 2'd2, 32'h0040_4000, 8'h00, 2'd2},  // R7 level-2 bus error
    '{32'hFFC0_0000, 1'b0, 2'd1, 32'hFFC0_0000, 8'h00, 2'd1}   // R2 last directory slot
  };

  task automatic start(input logic [31:0] va, input logic wr);
    @(negedge clk);
    nreq = 0;
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    int g = 0;
    while (!rsp_valid && g < 200) begin @(negedge clk); g++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 no rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0,
          "R1 idle after reset", {req_ready, rsp_valid, mem_req_valid}, 3'b100);

    for (int i = 0; i < NV; i++) begin
      lat = 1 + (i % 3);
      start(VECS[i].va, VECS[i].wr);
      wait_rsp();
      check(rsp_valid == 1'b1, $sformatf("R9 rsp seen v%0d", i), rsp_valid, 1);
      check(rsp_kind == VECS[i].kind, $sformatf("R5/R6/R7 kind v%0d", i), rsp_kind, VECS[i].kind);
      check(rsp_addr == VECS[i].addr, $sformatf("R4 addr v%0d", i), rsp_addr, VECS[i].addr);
      check(rsp_flags == VECS[i].flags, $sformatf("R4 flags v%0d", i), rsp_flags, VECS[i].flags);
      check(rsp_write == VECS[i].wr, $sformatf("R9 write v%0d", i), rsp_write, VECS[i].wr);
      check(nreq == VECS[i].nreq, $sformatf("R5/R7 fetch count v%0d", i), nreq, VECS[i].nreq);
      check(a1 == 32'h0001_0000 + 4 * VECS[i].va[31:22], $sformatf("R2 l1 addr v%0d", i),
            a1, 32'h0001_0000 + 4 * VECS[i].va[31:22]);
      if (VECS[i].nreq == 2)
        check(a2 == 32'h0002_0000 + 4 * VECS[i].va[21:12], $sformatf("R3 l2 addr v%0d", i),
              a2, 32'h0002_0000 + 4 * VECS[i].va[21:12]);
      @(negedge clk);
      check(rsp_valid == 1'b0, $sformatf("R9 rsp one cycle v%0d", i), rsp_valid, 0);
    end

    // R8: a request presented while busy is ignored
    lat = 3;
    start(32'h0040_0ABC, 1'b0);
    req_vaddr = 32'h0080_0000; req_write = 1'b1; req_valid = 1'b1;
    begin
      bit busy_ok = 1'b1;
      int g = 0;
      while (!rsp_valid && g < 200) begin
        if (req_ready) busy_ok = 1'b0;
        @(negedge clk); g++;
      end
      req_valid = 1'b0;
      check(busy_ok, "R8 not ready while walking", busy_ok, 1);
    end
    check(rsp_addr == 32'hABCD_EABC && rsp_kind == 2'd0, "R8 first request kept",
          rsp_addr, 32'hABCD_EABC);
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready after response", req_ready, 1);
    repeat (4) @(negedge clk);
    check(nreq == 2, "R8 ignored request made no fetch", nreq, 2);

    report();
  end
endmodule